// File: doc/BRIEF.md
# Wait-State Trace/Interrupt Sequencer

This block is the control sequencer that sits at the instruction boundary of a small 16-bit processor. Each time an instruction finishes, it chooses between servicing a pending interrupt, taking a single-step trace trap and letting the next instruction fetch proceed. When the finished instruction is a halt-until-interrupt (WAIT), it runs an idle loop that holds fetch off until an interrupt or a console halt ends it.

The idle loop has two forms. With the trace bit clear, it alternates between two states. With the trace bit set, it runs a four-state loop that never raises a trace trap while idling. The trap is owed instead to the instruction after WAIT. A return-from-trap boundary never raises a new trace trap, so the instruction it returns to runs once before the trap. Services are reported as single-cycle pulses carrying an 8-bit vector address. The current sequencer state is exposed as a 3-bit code.

Top module: `wait_trace_seq`

## Requirements
- R1: After reset, `fetch_en` is 1, `svc_valid` is 0 and `loop_state` is 0 (run). No trace trap is pending, so an instruction completing with `t_bit` clear produces no service.
- R2: If `irq_req` is high on a cycle where `insn_done` is high in the run state, then on the next cycle `svc_valid` is high for exactly one cycle, `svc_vec` equals the `irq_vec` that was sampled, and `fetch_en` is low. Fetch resumes the cycle after that.
- R3: An `insn_done` with `t_bit` high, `insn_is_wait` low, `rtt_done` low and no interrupt produces a one-cycle service with vector octal 014 (0x0C) on the next cycle.
- R4: A WAIT (`insn_done` with `insn_is_wait`) completed with `t_bit` clear enters loop code 1 and then alternates between codes 1 and 2. Loop codes are: 0 run, 1 idle-A, 2 idle-plain, 3 idle-T1, 4 idle-T2, 5 idle-T3, 6 service, 7 halted.
- R5: A WAIT completed with `t_bit` set loops through codes 1, 3, 4, 5 and then repeats. While it idles, `fetch_en` stays low and `svc_valid` stays low.
- R6: An `irq_req` seen in any idle state gives a service with `irq_vec` on the next cycle, then the run state with `fetch_en` high. The idle loop is not re-entered without a new WAIT. With `t_bit` set, the first ordinary instruction completed after the handler returns produces a trace service (octal 014).
- R7: A `rtt_done` boundary never starts a trace service, even with `t_bit` set.
- R8: When an interrupt and a new trace trap are both due at the same boundary, the interrupt service comes first. The trace service (octal 014) follows on the very next cycle, and run resumes after that.
- R9: With no interrupt present, `halt_req` in an idle state, or at a run-state boundary with no trace due, moves to code 7 with `fetch_en` low until `halt_req` drops. The next cycle is then the run state with `fetch_en` high, and the idle loop is not re-entered.
- R10: In an idle state, an interrupt takes priority over a simultaneous `halt_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | An instruction completed this cycle |
| insn_is_wait | input | 1 | The completing instruction is WAIT |
| rtt_done | input | 1 | A return-from-trap completed this cycle |
| t_bit | input | 1 | Trace bit of the processor status word (bit 4) |
| irq_req | input | 1 | Interrupt request, level |
| irq_vec | input | 8 | Vector address of the requesting interrupt |
| halt_req | input | 1 | Console halt request, level; dropping it continues |
| svc_valid | output | 1 | One-cycle service request |
| svc_vec | output | 8 | Vector address for the service request |
| loop_state | output | 3 | Current sequencer state code |
| fetch_en | output | 1 | Next instruction may be fetched |

## Verification
The state register drives `loop_state` directly, so a wrong idle successor, such as a trace loop falling into the plain loop, shows on the ports at the next clock. A lost or stale deferred trace shows one cycle after an interrupt service: either the 014 pulse is missing or there is an extra one. A wrong exit from WAIT or halt shows as `fetch_en` staying low, or as the idle codes coming back without a new WAIT.

// File: rtl/wtseq_pkg.sv
`timescale 1ns/1ps
package wtseq_pkg;
    localparam int VEC_W  = 8;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        ST_RUN  = 3'd0,
        ST_L00  = 3'd1,
        ST_L10  = 3'd2,
        ST_L20  = 3'd3,
        ST_L30  = 3'd4,
        ST_L11  = 3'd5,
        ST_SVC  = 3'd6,
        ST_HALT = 3'd7
    } seq_state_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_IRQ,
        ACT_TRACE,
        ACT_HALT,
        ACT_WAIT
    } seq_act_e;

    typedef struct packed {
        seq_state_e       state;
        logic             trc_pend;
        logic [VEC_W-1:0] vec;
    } seq_regs_t;
endpackage

// File: rtl/wtseq_arbiter.sv
`timescale 1ns/1ps
module wtseq_arbiter
    import wtseq_pkg::*;
(
    input  logic     enable,
    input  logic     irq,
    input  logic     trace,
    input  logic     halt,
    input  logic     wait_req,
    output seq_act_e act
);
    // Fixed priority: interrupt, trace, console halt, wait entry.
    always_comb begin
        act = ACT_NONE;
        if (enable) begin
            if (irq)           act = ACT_IRQ;
            else if (trace)    act = ACT_TRACE;
            else if (halt)     act = ACT_HALT;
            else if (wait_req) act = ACT_WAIT;
        end
    end
endmodule

// File: rtl/wtseq_loop_step.sv
`timescale 1ns/1ps
module wtseq_loop_step
    import wtseq_pkg::*;
(
    input  seq_state_e cur,
    input  logic       t_bit,
    output seq_state_e nxt
);
    // Idle loop successor: plain pair when T is clear, four-state ring when T is set.
    always_comb begin
        case (cur)
            ST_L00:  nxt = t_bit ? ST_L20 : ST_L10;
            ST_L10:  nxt = ST_L00;
            ST_L20:  nxt = ST_L30;
            ST_L30:  nxt = ST_L11;
            ST_L11:  nxt = ST_L00;
            default: nxt = ST_L00;
        endcase
    end
endmodule

// File: rtl/wait_trace_seq.sv
`timescale 1ns/1ps
module wait_trace_seq
    import wtseq_pkg::*;
#(
    parameter logic [VEC_W-1:0] TRACE_VEC = 8'o014
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  logic             insn_is_wait,
    input  logic             rtt_done,
    input  logic             t_bit,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic             halt_req,
    output logic             svc_valid,
    output logic [VEC_W-1:0] svc_vec,
    output logic [CODE_W-1:0] loop_state,
    output logic             fetch_en
);
    seq_regs_t  regs_q, regs_d;
    seq_state_e step_nxt;
    seq_act_e   act;
    logic       in_loop;
    logic       boundary;
    logic       trace_new;
    logic       wait_new;

    assign in_loop   = (regs_q.state == ST_L00) || (regs_q.state == ST_L10) ||
                       (regs_q.state == ST_L20) || (regs_q.state == ST_L30) ||
                       (regs_q.state == ST_L11);
    assign boundary  = (regs_q.state == ST_RUN) && (insn_done || rtt_done);
    // A return-from-trap boundary and a WAIT never start a trace trap.
    assign trace_new = insn_done && !rtt_done && !insn_is_wait && t_bit;
    assign wait_new  = insn_done && insn_is_wait && !rtt_done;

    wtseq_arbiter u_arb (
        .enable   (boundary || in_loop),
        .irq      (irq_req),
        .trace    (boundary && trace_new),
        .halt     (halt_req),
        .wait_req (boundary && wait_new),
        .act      (act)
    );

    wtseq_loop_step u_step (
        .cur   (regs_q.state),
        .t_bit (t_bit),
        .nxt   (step_nxt)
    );

    always_comb begin
        regs_d = regs_q;
        case (regs_q.state)
            ST_SVC: begin
                if (regs_q.trc_pend) begin
                    regs_d.vec      = TRACE_VEC;
                    regs_d.trc_pend = 1'b0;
                end else begin
                    regs_d.state = ST_RUN;
                end
            end
            ST_HALT: begin
                if (!halt_req) regs_d.state = ST_RUN;
            end
            default: begin
                case (act)
                    ACT_IRQ: begin
                        regs_d.state    = ST_SVC;
                        regs_d.vec      = irq_vec;
                        regs_d.trc_pend = boundary && trace_new;
                    end
                    ACT_TRACE: begin
                        regs_d.state = ST_SVC;
                        regs_d.vec   = TRACE_VEC;
                    end
                    ACT_HALT: regs_d.state = ST_HALT;
                    ACT_WAIT: regs_d.state = ST_L00;
                    default: begin
                        if (in_loop) regs_d.state = step_nxt;
                    end
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_RUN, trc_pend: 1'b0, vec: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign svc_valid  = (regs_q.state == ST_SVC);
    assign svc_vec    = regs_q.vec;
    assign loop_state = regs_q.state;
    assign fetch_en   = (regs_q.state == ST_RUN);

    // R2: interrupt at a boundary is serviced on the next cycle with its vector
    p_irq_svc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && insn_done && irq_req) |=> (svc_valid && !fetch_en && svc_vec == $past(irq_vec)));

    // R4: WAIT entry lands in the first idle state
    p_enter_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && insn_done && insn_is_wait && !rtt_done && !irq_req && !halt_req)
        |=> (loop_state == ST_L00));

    // R4: plain idle state returns to the first idle state
    p_plain_loop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_state == ST_L10 && !irq_req && !halt_req) |=> (loop_state == ST_L00));

    // R5: trace-aware loop walks its ring
    p_trace_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_state == ST_L20 && !irq_req && !halt_req) |=> (loop_state == ST_L30));

    // R5: no service while idling without an interrupt
    p_no_trap_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_loop && !irq_req) |=> !svc_valid);

    // R7: return-from-trap boundary raises no trace service
    p_rtt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && rtt_done && !irq_req) |=> !svc_valid);

    // R8: coincident trace follows the interrupt service on the next cycle
    p_trace_after_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && insn_done && !rtt_done && !insn_is_wait && t_bit && irq_req)
        |=> ##1 (svc_valid && svc_vec == TRACE_VEC));

    // R9: dropping the console halt resumes fetch
    p_halt_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_state == ST_HALT && !halt_req) |=> fetch_en);
endmodule

// File: tb/wait_trace_seq_test.sv
`timescale 1ns/1ps
module wait_trace_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       insn_done = 1'b0;
    logic       insn_is_wait = 1'b0;
    logic       rtt_done = 1'b0;
    logic       t_bit = 1'b0;
    logic       irq_req = 1'b0;
    logic [7:0] irq_vec = 8'h00;
    logic       halt_req = 1'b0;
    logic       svc_valid;
    logic [7:0] svc_vec;
    logic [2:0] loop_state;
    logic       fetch_en;

    int total = 0;
    int fails = 0;

    localparam logic [7:0] TRC = 8'o014;
    localparam logic [7:0] TTY = 8'o064;

    always #4 clk = ~clk;

    wait_trace_seq uut (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .insn_is_wait(insn_is_wait),
        .rtt_done(rtt_done), .t_bit(t_bit), .irq_req(irq_req), .irq_vec(irq_vec),
        .halt_req(halt_req), .svc_valid(svc_valid), .svc_vec(svc_vec),
        .loop_state(loop_state), .fetch_en(fetch_en)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_wait(input logic t);
        t_bit = t; insn_done = 1'b1; insn_is_wait = 1'b1;
        tick();
        insn_done = 1'b0; insn_is_wait = 1'b0;
    endtask

    task automatic leave_by_irq(input logic [7:0] v);
        irq_req = 1'b1; irq_vec = v;
        tick();
        irq_req = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        chk("R1", "fetch_en", fetch_en, 1);
        chk("R1", "svc_valid", svc_valid, 0);
        chk("R1", "loop_state", loop_state, 0);
        insn_done = 1'b1;
        tick();
        insn_done = 1'b0;
        chk("R1", "no trap", svc_valid, 0);
        chk("R1", "fetch after insn", fetch_en, 1);
    endtask

    task automatic t_irq_boundary();
        irq_req = 1'b1; irq_vec = TTY; insn_done = 1'b1;
        tick();
        insn_done = 1'b0; irq_req = 1'b0;
        chk("R2", "svc_valid", svc_valid, 1);
        chk("R2", "svc_vec", svc_vec, TTY);
        chk("R2", "fetch_en low", fetch_en, 0);
        tick();
        chk("R2", "pulse ends", svc_valid, 0);
        chk("R2", "fetch resumes", fetch_en, 1);
    endtask

    task automatic t_trace();
        t_bit = 1'b1; insn_done = 1'b1;
        tick();
        insn_done = 1'b0;
        chk("R3", "svc_valid", svc_valid, 1);
        chk("R3", "svc_vec", svc_vec, TRC);
        tick();
        chk("R3", "back to run", fetch_en, 1);
        t_bit = 1'b0;
    endtask

    task automatic t_wait_plain();
        do_wait(1'b0);
        for (int i = 0; i < 6; i++) begin
            chk("R4", "plain loop code", loop_state, (i % 2 == 0) ? 1 : 2);
            chk("R4", "fetch_en", fetch_en, 0);
            tick();
        end
        leave_by_irq(TTY);
    endtask

    task automatic t_wait_trace_irq();
        int ring [4] = '{1, 3, 4, 5};
        do_wait(1'b1);
        for (int i = 0; i < 12; i++) begin
            chk("R5", "trace loop code", loop_state, ring[i % 4]);
            chk("R5", "no service", svc_valid, 0);
            tick();
        end
        irq_req = 1'b1; irq_vec = TTY;
        tick();
        irq_req = 1'b0;
        chk("R6", "irq svc", svc_valid, 1);
        chk("R6", "irq vec", svc_vec, TTY);
        tick();
        chk("R6", "run after wait", loop_state, 0);
        chk("R6", "fetch_en", fetch_en, 1);
        rtt_done = 1'b1;
        tick();
        rtt_done = 1'b0;
        chk("R7", "no trace at return", svc_valid, 0);
        chk("R6", "not back in wait", loop_state, 0);
        insn_done = 1'b1;
        tick();
        insn_done = 1'b0;
        chk("R6", "trace after next insn", svc_valid, 1);
        chk("R6", "trace vec", svc_vec, TRC);
        tick();
        chk("R6", "run", fetch_en, 1);
        t_bit = 1'b0;
    endtask

    task automatic t_both();
        t_bit = 1'b1; irq_req = 1'b1; irq_vec = 8'o100; insn_done = 1'b1;
        tick();
        insn_done = 1'b0; irq_req = 1'b0;
        chk("R8", "irq first", svc_valid, 1);
        chk("R8", "irq vec", svc_vec, 8'o100);
        tick();
        chk("R8", "trace next", svc_valid, 1);
        chk("R8", "trace vec", svc_vec, TRC);
        tick();
        chk("R8", "run after", fetch_en, 1);
        chk("R8", "pulse over", svc_valid, 0);
        t_bit = 1'b0;
    endtask

    task automatic t_halt();
        do_wait(1'b0);
        tick();
        halt_req = 1'b1;
        tick();
        chk("R9", "halted", loop_state, 7);
        chk("R9", "fetch off", fetch_en, 0);
        tick(); tick();
        chk("R9", "stays halted", loop_state, 7);
        halt_req = 1'b0;
        tick();
        chk("R9", "continue", loop_state, 0);
        chk("R9", "fetch on", fetch_en, 1);
        tick(); tick();
        chk("R9", "no wait re-entry", loop_state, 0);
        halt_req = 1'b1; insn_done = 1'b1;
        tick();
        insn_done = 1'b0;
        chk("R9", "halt at boundary", loop_state, 7);
        halt_req = 1'b0;
        tick();
        chk("R9", "run again", fetch_en, 1);
    endtask

    task automatic t_prio();
        do_wait(1'b1);
        tick();
        irq_req = 1'b1; halt_req = 1'b1; irq_vec = 8'o060;
        tick();
        irq_req = 1'b0;
        chk("R10", "irq wins", svc_valid, 1);
        chk("R10", "irq vec", svc_vec, 8'o060);
        tick();
        chk("R10", "run after svc", loop_state, 0);
        halt_req = 1'b0;
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_irq_boundary();
        t_trace();
        t_wait_plain();
        t_wait_trace_irq();
        t_both();
        t_halt();
        t_prio();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule